// File: doc/BRIEF.md
# Torus Adaptive Route and Virtual Channel Selector

This block decides where a packet header goes next inside one router of a two-dimensional torus. It receives the header's destination coordinates and a small amount of routing state carried in the header: the dimension the packet last travelled in, whether it currently rides an escape channel, and the ring index where its present escape segment began. From these, the router's own coordinates and a per-port congestion vector, it picks an output port and a virtual channel. The result is registered behind a valid/ready handshake, with a one-cycle latency from acceptance.

Routing is always minimal. In each ring, the shorter wrap-around direction is taken. An adaptive packet may continue in its current dimension or turn, and it prefers whichever minimal port is not congested. If every minimal port is congested, the packet drops onto one of two escape channels. Escape routing is strictly dimension-ordered, with all X hops before any Y hop. The escape channel is chosen by comparing the ring index where the packet entered the current dimension with the destination index. That choice is recomputed whenever the packet enters a new dimension. A packet on an escape channel returns to the adaptive channel as soon as a minimal port is free. The updated dimension and entry index are returned so the next router can continue the scheme.

Top module: `torus_route_sel`

## Requirements
- R1: A header whose destination equals the local node is sent to the local port (port code 4) with virtual channel code 3, meaning no channel. Output dimension and entry are both 0.
- R2: In each ring, the forward distance is d = (destination − local) mod N. The positive port is used when 0 < d ≤ N/2 (integer division), so an exact half ring goes positive. The negative port is used otherwise. Port codes are: X positive = 0, X negative = 1, Y positive = 2, Y negative = 3.
- R3: The chosen port always reduces a nonzero distance. No port of a dimension whose distance is zero is ever chosen.
- R4: When exactly one minimal port exists and it is free, that port is used with the adaptive channel (code 0). When two minimal ports exist and exactly one is free, the free one is used. Bit k of `port_blocked` marks port code k as congested.
- R5: When two minimal ports exist and both are free, or both are congested, the port in the header's current dimension is preferred (`in_dim` 0 = X, 1 = Y).
- R6: When every minimal port is congested, the packet takes an escape channel. It goes on the X port if any X distance remains, and otherwise on the Y port.
- R7: The escape channel is code 1 when the entry index is smaller than the destination index in the escape dimension, and code 2 otherwise. The entry index is `in_entry` when `in_esc` is 1 and `in_dim` equals the escape dimension. Otherwise it is the local node's index in that dimension.
- R8: A header with `in_esc` = 1 that has a free minimal port is routed on the adaptive channel.
- R9: `out_dim` gives the dimension of the chosen port. `out_entry` gives the entry index used for an escape route, or the local index in the chosen dimension for an adaptive route.
- R10: `in_ready` is high exactly when the output register is empty or `out_ready` is high. An accepted header appears on the outputs one cycle later. The outputs hold steady while `out_valid` is high and `out_ready` is low.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header accepted this cycle when high with in_valid |
| in_dst_x | input | CW | Destination X index |
| in_dst_y | input | CW | Destination Y index |
| in_dim | input | 1 | Dimension of the previous hop (0 X, 1 Y) |
| in_esc | input | 1 | Packet currently on an escape channel |
| in_entry | input | CW | Ring index where the current escape segment began |
| port_blocked | input | 4 | Congestion flag per network output port |
| out_valid | output | 1 | Route result present |
| out_ready | input | 1 | Consumer takes the result |
| out_port | output | 3 | Chosen output port code |
| out_vc | output | 2 | Chosen virtual channel code |
| out_dim | output | 1 | Dimension of the chosen port |
| out_entry | output | CW | Entry index to forward in the header |

## Verification
The decision path has no internal state apart from the output register, so a wrong choice of distance, tie-break or escape channel shows up in the very next result that leaves the block. A broken holding register shows up differently: results change under backpressure, a header is lost, or one is duplicated. Each of these is visible in the first stalled or accepted cycle after the fault.

// File: rtl/torus_route_sel.sv
module torus_route_sel #(
  parameter int NX = 4,
  parameter int NY = 4,
  parameter int MY_X = 1,
  parameter int MY_Y = 2,
  localparam int CW = $clog2((NX > NY) ? NX : NY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_dst_x,
  input  logic [CW-1:0] in_dst_y,
  input  logic          in_dim,
  input  logic          in_esc,
  input  logic [CW-1:0] in_entry,
  input  logic [3:0]    port_blocked,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_port,
  output logic [1:0]    out_vc,
  output logic          out_dim,
  output logic [CW-1:0] out_entry
);

  localparam logic [2:0] P_XP = 3'd0, P_XN = 3'd1, P_YP = 3'd2, P_YN = 3'd3, P_LOC = 3'd4;
  localparam logic [1:0] VC_AD = 2'd0, VC_E0 = 2'd1, VC_E1 = 2'd2, VC_NONE = 2'd3;

  localparam logic [CW:0]   NXV = (CW+1)'(NX);
  localparam logic [CW:0]   NYV = (CW+1)'(NY);
  localparam logic [CW:0]   MXV = (CW+1)'(MY_X);
  localparam logic [CW:0]   MYV = (CW+1)'(MY_Y);
  localparam logic [CW:0]   HXV = (CW+1)'(NX / 2);
  localparam logic [CW:0]   HYV = (CW+1)'(NY / 2);
  localparam logic [CW-1:0] MXI = CW'(MY_X);
  localparam logic [CW-1:0] MYI = CW'(MY_Y);

  logic [CW:0]   dxe, dye, x_dist, y_dist;
  logic          x_need, y_need, x_blk, y_blk, pick_x, sel_blk, at_home, go_esc, esc_dim;
  logic [2:0]    x_port, y_port, sel_port, esc_port, nxt_port;
  logic [1:0]    esc_vc, nxt_vc;
  logic [CW-1:0] dst_idx, home_idx, esc_src, nxt_entry;
  logic          nxt_dim;

  assign dxe    = {1'b0, in_dst_x};
  assign dye    = {1'b0, in_dst_y};
  assign x_dist = (dxe >= MXV) ? dxe - MXV : dxe + NXV - MXV;
  assign y_dist = (dye >= MYV) ? dye - MYV : dye + NYV - MYV;
  assign x_need = |x_dist;
  assign y_need = |y_dist;
  assign x_port = (x_dist <= HXV) ? P_XP : P_XN;
  assign y_port = (y_dist <= HYV) ? P_YP : P_YN;
  assign x_blk  = port_blocked[x_port[1:0]];
  assign y_blk  = port_blocked[y_port[1:0]];

  assign pick_x   = x_need && (!y_need || ((x_blk != y_blk) ? !x_blk : !in_dim));
  assign sel_port = pick_x ? x_port : y_port;
  assign sel_blk  = pick_x ? x_blk : y_blk;
  assign at_home  = !x_need && !y_need;
  assign go_esc   = !at_home && sel_blk;

  assign esc_dim  = !x_need;
  assign esc_port = x_need ? x_port : y_port;
  assign home_idx = esc_dim ? MYI : MXI;
  assign dst_idx  = esc_dim ? in_dst_y : in_dst_x;
  assign esc_src  = (in_esc && (in_dim == esc_dim)) ? in_entry : home_idx;
  assign esc_vc   = (esc_src < dst_idx) ? VC_E0 : VC_E1;

  always_comb begin
    if (at_home) begin
      nxt_port = P_LOC;   nxt_vc = VC_NONE; nxt_dim = 1'b0;    nxt_entry = '0;
    end else if (go_esc) begin
      nxt_port = esc_port; nxt_vc = esc_vc;  nxt_dim = esc_dim; nxt_entry = esc_src;
    end else begin
      nxt_port = sel_port; nxt_vc = VC_AD;   nxt_dim = !pick_x;
      nxt_entry = pick_x ? MXI : MYI;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= P_LOC;
      out_vc    <= VC_NONE;
      out_dim   <= 1'b0;
      out_entry <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_port  <= nxt_port;
        out_vc    <= nxt_vc;
        out_dim   <= nxt_dim;
        out_entry <= nxt_entry;
      end
    end
  end

  p_local_novc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_port == P_LOC) |-> (out_vc == VC_NONE));

  p_no_x_when_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_dst_x == MXI) |=> (out_port != P_XP) && (out_port != P_XN));

  p_escape_x_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_dst_x != MXI) |=>
      (out_vc == VC_AD) || (out_port == P_XP) || (out_port == P_XN));

  p_dim_matches_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_port != P_LOC) |-> (out_dim == ((out_port == P_YP) || (out_port == P_YN))));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_port) && $stable(out_vc)
      && $stable(out_dim) && $stable(out_entry));

endmodule

// File: tb/torus_route_sel_bench.sv
module torus_route_sel_bench;
  localparam int NX = 4, NY = 4, MX = 1, MY = 2, CW = 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_dim = 0, in_esc = 0, out_ready = 0;
  logic [CW-1:0] in_dst_x = 0, in_dst_y = 0, in_entry = 0;
  logic [3:0] port_blocked = 0;
  logic in_ready, out_valid, out_dim;
  logic [2:0] out_port;
  logic [1:0] out_vc;
  logic [CW-1:0] out_entry;

  int errors = 0, checks = 0;
  bit done = 0;

  bit m_valid = 0;
  int m_port, m_vc, m_dim, m_entry;
  string m_tag;

  torus_route_sel #(.NX(NX), .NY(NY), .MY_X(MX), .MY_Y(MY)) u_torus_route_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst_x(in_dst_x), .in_dst_y(in_dst_y), .in_dim(in_dim), .in_esc(in_esc),
    .in_entry(in_entry), .port_blocked(port_blocked), .out_valid(out_valid),
    .out_ready(out_ready), .out_port(out_port), .out_vc(out_vc), .out_dim(out_dim),
    .out_entry(out_entry));

  always #2 clk = ~clk;

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: returns the expected route for one header.
  task automatic ref_route(input int dx, dy, dim, esc, entry, input logic [3:0] blk,
                           output int port, vc, odim, oentry, output string tag);
    int xd, yd, xp, yp, cand[$], chosen, ed, src, di;
    xd = (dx - MX + NX) % NX;
    yd = (dy - MY + NY) % NY;
    xp = (2 * xd <= NX) ? 0 : 1;
    yp = (2 * yd <= NY) ? 2 : 3;
    if (xd != 0) cand.push_back(xp);
    if (yd != 0) cand.push_back(yp);
    if (cand.size() == 0) begin
      port = 4; vc = 3; odim = 0; oentry = 0; tag = "R1"; return;
    end
    if (cand.size() == 1) begin
      chosen = cand[0]; tag = "R4";
    end else if (blk[xp] != blk[yp]) begin
      chosen = blk[xp] ? yp : xp; tag = "R4";
    end else begin
      chosen = (dim == 0) ? xp : yp; tag = "R5";
    end
    if (!blk[chosen]) begin
      port = chosen; vc = 0; odim = chosen / 2;
      oentry = (odim == 0) ? MX : MY;
      if (esc) tag = "R8";
      return;
    end
    ed = (xd != 0) ? 0 : 1;
    port = (ed == 0) ? xp : yp;
    di = (ed == 0) ? dx : dy;
    src = (esc && dim == ed) ? entry : ((ed == 0) ? MX : MY);
    vc = (src < di) ? 1 : 2;
    odim = ed; oentry = src; tag = "R7";
  endtask

  task automatic step(bit v, int dx, int dy, bit dim, bit esc, int entry,
                      logic [3:0] blk, bit rdy, string force_tag);
    bit exp_ready;
    in_valid = v; in_dst_x = CW'(dx); in_dst_y = CW'(dy); in_dim = dim;
    in_esc = esc; in_entry = CW'(entry); port_blocked = blk; out_ready = rdy;
    #1;
    exp_ready = !m_valid || rdy;
    check("R10", int'(in_ready), int'(exp_ready), "in_ready");
    if (m_valid && rdy) m_valid = 0;
    if (v && exp_ready) begin
      m_valid = 1;
      ref_route(dx, dy, dim, esc, entry, blk, m_port, m_vc, m_dim, m_entry, m_tag);
      if (force_tag != "") m_tag = force_tag;
    end
    @(negedge clk);
    check("R10", int'(out_valid), int'(m_valid), "out_valid");
    if (m_valid) begin
      check(m_tag, int'(out_port), m_port, "out_port");
      check(m_tag, int'(out_vc), m_vc, "out_vc");
      check("R9", int'(out_dim), m_dim, "out_dim");
      check("R9", int'(out_entry), m_entry, "out_entry");
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", int'(out_valid), 0, "out_valid in reset");
    check("R11", int'(in_ready), 1, "in_ready in reset");
    rst_n = 1;
    @(negedge clk);
    check("R11", int'(out_valid), 0, "out_valid after reset");

    step(1, 1, 2, 0, 0, 0, 4'b0000, 1, "R1");     // home node
    step(1, 3, 2, 0, 0, 0, 4'b0000, 1, "R2");     // half ring: X positive
    step(1, 0, 2, 0, 0, 0, 4'b0000, 1, "R2");     // X negative by wrap
    step(1, 1, 0, 1, 0, 0, 4'b0000, 1, "R2");     // half ring: Y positive
    step(1, 1, 1, 1, 0, 0, 4'b0000, 1, "R3");     // X aligned, Y only
    step(1, 2, 3, 0, 0, 0, 4'b0001, 1, "R4");     // X congested, take Y
    step(1, 2, 3, 0, 0, 0, 4'b0000, 1, "R5");     // tie, stay in X
    step(1, 2, 3, 1, 0, 0, 4'b0101, 1, "R5");     // both congested: escape X
    step(1, 2, 3, 1, 0, 0, 4'b0101, 1, "R6");
    step(1, 1, 3, 0, 1, 0, 4'b0100, 1, "R7");     // new dimension: recompute from local Y
    step(1, 1, 1, 1, 1, 3, 4'b1000, 1, "R7");     // same dimension: keep entry 3 -> VC1
    step(1, 0, 2, 0, 1, 0, 4'b0010, 1, "R7");     // entry 0 < dest 0? no -> VC1
    step(1, 2, 2, 0, 1, 0, 4'b0010, 1, "R8");     // escaped but free -> adaptive
    // R10: backpressure holds and stalls
    step(1, 2, 3, 0, 0, 0, 4'b0000, 0, "");
    step(1, 0, 0, 1, 0, 0, 4'b0000, 0, "");
    step(0, 0, 0, 0, 0, 0, 4'b0000, 1, "");
    step(0, 0, 0, 0, 0, 0, 4'b0000, 1, "");

    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, NX-1), $urandom_range(0, NY-1),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 3),
           4'($urandom_range(0, 15)), $urandom_range(0, 3) != 0, "");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule